// File: doc/BRIEF.md
# Transaction Status Word Controller

This block holds the status of the single transaction owned by one hardware thread. The status has three parts: whether the transaction is running, committing or aborting; whether it is on the processor or swapped out; and whether its speculative lines are all still in local buffers or some have spilled to memory. Only seven combinations of these parts are legal. Each one gets a 3-bit code, and the block changes that code only along legal paths.

The thread drives local events into the block: transaction begin and end (nesting is flattened into one outer transaction by a depth counter), eviction of a transactional line, context-switch suspend and reschedule, and completion handshakes from the logic that later applies or discards the buffered data. Other agents abort the transaction with a compare-and-swap request that carries the state code they expect to find. The outermost end of a transaction that has spilled lines moves it into the committing state. That move is the commit point, and after it every abort attempt is refused.

Top module: `txn_status_fsm`

## Requirements
- R1: Reset, asynchronous and active low, puts the block in the non-transactional state with depth 0. In that state every pulse output is low, committed_o is low and no_abort_o is high.
- R2: State codes are NONT=0, RAL=1 (running, active, local), RAO=2 (running, active, overflowed), RSO=3 (running, swapped, overflowed), BAO=4 (aborting, active), BSO=5 (aborting, swapped) and CAO=6 (committing, active). committed_o is high only in CAO. no_abort_o is high in NONT, BAO, BSO and CAO.
- R3: A begin in NONT gives RAL with depth 1. A begin in RAL or RAO adds 1 to the depth. A begin when the depth is already 2^DEPTH_W-1 is ignored and flagged as an error.
- R4: An end when the depth is above 1 subtracts 1 from the depth. An end when the depth is 1 moves RAL to NONT, or moves RAO to CAO, and in both cases clears the depth.
- R5: An eviction moves RAL to RAO. An eviction in RAO leaves the state unchanged and raises no error.
- R6: A suspend in RAL gives RAO for one flush cycle and then RSO. A suspend in RAO gives RSO directly, and a suspend in BAO gives BSO. Any local request that arrives during the flush cycle is ignored and flagged as an error, but the move to the swapped state still takes place.
- R7: A resume moves RSO to RAO and BSO to BAO, and the depth is kept.
- R8: An abort request succeeds when its expected code equals the current state and that state is RAL, RAO or RSO. Success moves RAL to NONT (depth 0), RAO to BAO and RSO to BSO, and abort_ok_o pulses on the next cycle. Local requests in the same cycle are dropped and raise no error. A success during the flush cycle still finishes in BSO.
- R9: An abort request whose expected code differs from the state, or that arrives in a state other than RAL, RAO or RSO (CAO included), leaves the state unchanged and pulses abort_fail_o on the next cycle.
- R10: CAO stays in CAO until commit_done_i, then moves to NONT. BAO moves to NONT on abort_done_i. The depth is 0 after either move.
- R11: A local request that is illegal in the current state leaves state and depth unchanged and pulses err_o for one cycle. Examples are suspend or end in NONT, begin in CAO or BSO, and commit_done_i in BAO.
- R12: When several local requests arrive in the same cycle, only the highest-priority one takes effect. The priority order is resume, suspend, evict, end, begin, commit_done, abort_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_i | input | 1 | Transaction begin (nestable) |
| end_i | input | 1 | Transaction end |
| evict_i | input | 1 | A transactional line left the local buffer |
| suspend_i | input | 1 | Context switch out |
| resume_i | input | 1 | Reschedule |
| abort_req_i | input | 1 | Remote compare-and-swap abort request |
| abort_expect_i | input | 3 | State code the requester expects |
| commit_done_i | input | 1 | Physical commit finished |
| abort_done_i | input | 1 | Physical abort cleanup finished |
| state_o | output | 3 | Current state code |
| committed_o | output | 1 | Transaction is past its commit point |
| no_abort_o | output | 1 | An abort request cannot succeed now |
| depth_o | output | DEPTH_W | Nesting depth |
| err_o | output | 1 | One-cycle pulse: an illegal request was ignored |
| abort_ok_o | output | 1 | One-cycle pulse: abort swap succeeded |
| abort_fail_o | output | 1 | One-cycle pulse: abort swap refused |

## Verification
The hardest case to reach is a remote abort that lands inside the one-cycle flush window of a context switch out of RAL. In that window the state reads RAO while the move to swapped is already committed. The stimulus issues a suspend from RAL and, on the very next cycle, an abort that expects RAO. It then checks the path RAO, BAO, BSO, and checks that a later reschedule gives BAO. A local request placed in the same window shows that the window rejects local traffic while the swap still completes.

// File: rtl/txn_status_fsm.sv
module txn_status_fsm #(
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               begin_i,
  input  logic               end_i,
  input  logic               evict_i,
  input  logic               suspend_i,
  input  logic               resume_i,
  input  logic               abort_req_i,
  input  logic [2:0]         abort_expect_i,
  input  logic               commit_done_i,
  input  logic               abort_done_i,
  output logic [2:0]         state_o,
  output logic               committed_o,
  output logic               no_abort_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               err_o,
  output logic               abort_ok_o,
  output logic               abort_fail_o
);
  localparam logic [2:0] NONT = 3'd0, RAL = 3'd1, RAO = 3'd2, RSO = 3'd3,
                         BAO  = 3'd4, BSO = 3'd5, CAO = 3'd6;
  localparam logic [DEPTH_W-1:0] DMAX = '1;
  localparam logic [DEPTH_W-1:0] DONE = DEPTH_W'(1);

  logic [2:0]         state_q, state_n;
  logic [DEPTH_W-1:0] depth_q, depth_n;
  logic               pend_q, pend_n;
  logic               err_q, err_n, ok_q, ok_n, fail_q, fail_n;
  logic               running, cas_hit, any_local;

  assign running   = (state_q == RAL) || (state_q == RAO) || (state_q == RSO);
  assign cas_hit   = abort_req_i && (abort_expect_i == state_q) && running;
  assign any_local = begin_i | end_i | evict_i | suspend_i | resume_i |
                     commit_done_i | abort_done_i;

  always_comb begin
    state_n = state_q;
    depth_n = depth_q;
    pend_n  = pend_q;
    err_n   = 1'b0;
    ok_n    = abort_req_i && cas_hit;
    fail_n  = abort_req_i && !cas_hit;
    if (pend_q) begin
      if (cas_hit) state_n = BAO;
      else begin
        state_n = (state_q == RAO) ? RSO : BSO;
        pend_n  = 1'b0;
      end
      err_n = any_local;
    end else if (cas_hit) begin
      case (state_q)
        RAL: begin state_n = NONT; depth_n = '0; end
        RAO: state_n = BAO;
        default: state_n = BSO;
      endcase
    end else if (resume_i) begin
      if (state_q == RSO)      state_n = RAO;
      else if (state_q == BSO) state_n = BAO;
      else                     err_n = 1'b1;
    end else if (suspend_i) begin
      case (state_q)
        RAL: begin state_n = RAO; pend_n = 1'b1; end
        RAO: state_n = RSO;
        BAO: state_n = BSO;
        default: err_n = 1'b1;
      endcase
    end else if (evict_i) begin
      if (state_q == RAL)      state_n = RAO;
      else if (state_q != RAO) err_n = 1'b1;
    end else if (end_i) begin
      if ((state_q == RAL || state_q == RAO) && depth_q != '0) begin
        if (depth_q != DONE) depth_n = depth_q - DONE;
        else begin
          state_n = (state_q == RAL) ? NONT : CAO;
          depth_n = '0;
        end
      end else err_n = 1'b1;
    end else if (begin_i) begin
      if (state_q == NONT) begin
        state_n = RAL;
        depth_n = DONE;
      end else if ((state_q == RAL || state_q == RAO) && depth_q != DMAX)
        depth_n = depth_q + DONE;
      else err_n = 1'b1;
    end else if (commit_done_i) begin
      if (state_q == CAO) begin state_n = NONT; depth_n = '0; end
      else err_n = 1'b1;
    end else if (abort_done_i) begin
      if (state_q == BAO) begin state_n = NONT; depth_n = '0; end
      else err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NONT;
      depth_q <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      depth_q <= depth_n;
      pend_q  <= pend_n;
      err_q   <= err_n;
      ok_q    <= ok_n;
      fail_q  <= fail_n;
    end
  end

  assign state_o      = state_q;
  assign depth_o      = depth_q;
  assign err_o        = err_q;
  assign abort_ok_o   = ok_q;
  assign abort_fail_o = fail_q;
  assign committed_o  = (state_q == CAO);
  assign no_abort_o   = !running;

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= CAO);
  assert_nont_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == NONT) |-> (depth_q == '0));
  assert_flush_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && state_q == RAO && !(abort_req_i && abort_expect_i == RAO))
      |=> (state_q == RSO));
  assert_resume_aborted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BSO && resume_i) |=> (state_q == BAO));
  assert_mismatch_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req_i && abort_expect_i != state_q) |=> (abort_fail_o && !abort_ok_o));
  assert_commit_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAO && abort_req_i) |=> (abort_fail_o && state_q == CAO));
  assert_commit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAO && !commit_done_i) |=> (state_q == CAO));
endmodule

// File: tb/tb_txn_status_fsm.sv
module tb_txn_status_fsm;
  localparam int DW = 4;
  localparam int NV = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic begin_i = 0, end_i = 0, evict_i = 0, suspend_i = 0, resume_i = 0;
  logic abort_req_i = 0, commit_done_i = 0, abort_done_i = 0;
  logic [2:0] abort_expect_i = '0;
  logic [2:0] state_o;
  logic committed_o, no_abort_o, err_o, abort_ok_o, abort_fail_o;
  logic [DW-1:0] depth_o;
  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  txn_status_fsm #(.DEPTH_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .begin_i(begin_i), .end_i(end_i),
    .evict_i(evict_i), .suspend_i(suspend_i), .resume_i(resume_i),
    .abort_req_i(abort_req_i), .abort_expect_i(abort_expect_i),
    .commit_done_i(commit_done_i), .abort_done_i(abort_done_i),
    .state_o(state_o), .committed_o(committed_o), .no_abort_o(no_abort_o),
    .depth_o(depth_o), .err_o(err_o), .abort_ok_o(abort_ok_o),
    .abort_fail_o(abort_fail_o));

  // {req, op, expect, state, depth, err/ok/fail}
  // ops: 0 idle 1 begin 2 end 3 evict 4 suspend 5 resume 6 abort 7 cdone 8 adone
  localparam logic [20:0] VEC [NV] = '{
    {4'd11, 4'd4, 3'd0, 3'd0, 4'd0, 3'b100}, // R11 suspend in NONT
    {4'd11, 4'd2, 3'd0, 3'd0, 4'd0, 3'b100}, // R11 end in NONT
    {4'd9,  4'd6, 3'd0, 3'd0, 4'd0, 3'b001}, // R9 abort in NONT
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd1, 3'b000}, // R3
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd2, 3'b000},
    {4'd4,  4'd2, 3'd0, 3'd1, 4'd1, 3'b000}, // R4
    {4'd4,  4'd2, 3'd0, 3'd0, 4'd0, 3'b000},
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd1, 3'b000},
    {4'd5,  4'd3, 3'd0, 3'd2, 4'd1, 3'b000}, // R5
    {4'd5,  4'd3, 3'd0, 3'd2, 4'd1, 3'b000},
    {4'd3,  4'd1, 3'd0, 3'd2, 4'd2, 3'b000},
    {4'd4,  4'd2, 3'd0, 3'd2, 4'd1, 3'b000},
    {4'd4,  4'd2, 3'd0, 3'd6, 4'd0, 3'b000}, // commit point
    {4'd9,  4'd6, 3'd6, 3'd6, 4'd0, 3'b001}, // R9 refused in CAO
    {4'd11, 4'd1, 3'd0, 3'd6, 4'd0, 3'b100},
    {4'd10, 4'd0, 3'd0, 3'd6, 4'd0, 3'b000}, // R10
    {4'd10, 4'd7, 3'd0, 3'd0, 4'd0, 3'b000},
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd1, 3'b000},
    {4'd6,  4'd4, 3'd0, 3'd2, 4'd1, 3'b000}, // R6 flush
    {4'd6,  4'd0, 3'd0, 3'd3, 4'd1, 3'b000},
    {4'd7,  4'd5, 3'd0, 3'd2, 4'd1, 3'b000}, // R7
    {4'd6,  4'd4, 3'd0, 3'd3, 4'd1, 3'b000},
    {4'd8,  4'd6, 3'd3, 3'd5, 4'd1, 3'b010}, // R8
    {4'd7,  4'd5, 3'd0, 3'd4, 4'd1, 3'b000},
    {4'd11, 4'd7, 3'd0, 3'd4, 4'd1, 3'b100},
    {4'd10, 4'd8, 3'd0, 3'd0, 4'd0, 3'b000},
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd1, 3'b000},
    {4'd9,  4'd6, 3'd2, 3'd1, 4'd1, 3'b001},
    {4'd8,  4'd6, 3'd1, 3'd0, 4'd0, 3'b010},
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd1, 3'b000},
    {4'd5,  4'd3, 3'd0, 3'd2, 4'd1, 3'b000},
    {4'd8,  4'd6, 3'd2, 3'd4, 4'd1, 3'b010},
    {4'd6,  4'd4, 3'd0, 3'd5, 4'd1, 3'b000},
    {4'd11, 4'd1, 3'd0, 3'd5, 4'd1, 3'b100},
    {4'd7,  4'd5, 3'd0, 3'd4, 4'd1, 3'b000},
    {4'd10, 4'd8, 3'd0, 3'd0, 4'd0, 3'b000},
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd1, 3'b000},
    {4'd6,  4'd4, 3'd0, 3'd2, 4'd1, 3'b000},
    {4'd8,  4'd6, 3'd2, 3'd4, 4'd1, 3'b010}, // abort inside flush
    {4'd6,  4'd0, 3'd0, 3'd5, 4'd1, 3'b000},
    {4'd7,  4'd5, 3'd0, 3'd4, 4'd1, 3'b000},
    {4'd10, 4'd8, 3'd0, 3'd0, 4'd0, 3'b000},
    {4'd3,  4'd1, 3'd0, 3'd1, 4'd1, 3'b000},
    {4'd6,  4'd4, 3'd0, 3'd2, 4'd1, 3'b000},
    {4'd6,  4'd3, 3'd0, 3'd3, 4'd1, 3'b100}, // local request in flush
    {4'd7,  4'd5, 3'd0, 3'd2, 4'd1, 3'b000},
    {4'd4,  4'd2, 3'd0, 3'd6, 4'd0, 3'b000},
    {4'd10, 4'd7, 3'd0, 3'd0, 4'd0, 3'b000}
  };

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int op, input logic [2:0] e);
    begin_i = (op == 1); end_i = (op == 2); evict_i = (op == 3);
    suspend_i = (op == 4); resume_i = (op == 5); abort_req_i = (op == 6);
    commit_done_i = (op == 7); abort_done_i = (op == 8); abort_expect_i = e;
  endtask

  task automatic step(input int op, input logic [2:0] e);
    drive(op, e);
    @(posedge clk); @(negedge clk);
    drive(0, 3'd0);
  endtask

  task automatic chk_state(input int req, input int st, input int dp);
    chk(req, "state", int'(state_o), st);
    chk(req, "depth", int'(depth_o), dp);
    chk(2, "committed", int'(committed_o), int'(st == 6));
    chk(2, "no_abort", int'(no_abort_o), int'(st == 0 || st >= 4));
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk_state(1, 0, 0);
    chk(1, "err", int'(err_o), 0);
    chk(1, "ok", int'(abort_ok_o), 0);
    chk(1, "fail", int'(abort_fail_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      int rq;
      v = VEC[i];
      rq = int'(v[20:17]);
      step(int'(v[16:13]), v[12:10]);
      chk_state(rq, int'(v[9:7]), int'(v[6:3]));
      chk(rq, "err", int'(err_o), int'(v[2]));
      chk(rq, "abort_ok", int'(abort_ok_o), int'(v[1]));
      chk(rq, "abort_fail", int'(abort_fail_o), int'(v[0]));
    end

    // R3 depth saturation
    for (int k = 0; k < (1 << DW) - 1; k++) step(1, 3'd0);
    chk_state(3, 1, (1 << DW) - 1);
    step(1, 3'd0);
    chk(3, "err at max depth", int'(err_o), 1);
    chk_state(3, 1, (1 << DW) - 1);
    for (int k = 0; k < (1 << DW) - 1; k++) step(2, 3'd0);
    chk_state(4, 0, 0);

    // R12 priority: evict beats end
    step(1, 3'd0);
    begin_i = 0; evict_i = 1; end_i = 1;
    @(posedge clk); @(negedge clk); drive(0, 3'd0);
    chk_state(12, 2, 1);
    chk(12, "err", int'(err_o), 0);
    // R12 resume beats suspend (resume illegal in RAO)
    resume_i = 1; suspend_i = 1;
    @(posedge clk); @(negedge clk); drive(0, 3'd0);
    chk_state(12, 2, 1);
    chk(12, "err", int'(err_o), 1);
    // R8 abort drops a simultaneous end without error
    abort_req_i = 1; abort_expect_i = 3'd2; end_i = 1;
    @(posedge clk); @(negedge clk); drive(0, 3'd0);
    chk_state(8, 4, 1);
    chk(8, "err", int'(err_o), 0);
    chk(8, "abort_ok", int'(abort_ok_o), 1);

    // R1 reset from an aborting state
    rst_n = 1'b0;
    #3;
    chk_state(1, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state(1, 0, 0);

    finish_up();
  end
endmodule